// File: doc/BRIEF.md
# Clock Source Selector With Failover

This block picks the system clock from four sources: a fast internal RC clock, a slow internal RC clock, and two external clock inputs. Software writes a 2-bit source code at any time. The output moves to the new source through a handover that never produces a shortened high or low phase. The old source is gated off in its own low phase. Only after that is seen does the new source gate itself on, also in its own low phase.

While an external input is selected, a supervisor runs in the slow RC domain and watches that input for rising edges. If the input goes quiet for a fixed number of slow cycles, the selection falls back to the fast RC clock without software action. A sticky failure flag is then set, and an interrupt is raised if the interrupt enable is high. The flag stays set until software clears it. While it is set, external sources cannot be selected again. Control and readback run in the fast RC domain. The fast clock is taken to be always running.

Top module: `clk_failover_sel`

## Requirements
- R1: After reset the source code reads 0 (fast RC), the failure flag and the interrupt are low, and `clk_out` runs at the fast RC clock once the handover has settled.
- R2: A write with `wr_en` high loads `wr_mode` into the source code, which reads back one fast cycle later. After the handover, `clk_out` has the period of the chosen source. The codes are 0 = fast RC, 1 = slow RC, 2 = external input 0, 3 = external input 1.
- R3: No high or low phase of `clk_out` is shorter than the shortest half period among the sources, including during every handover.
- R4: At most one source's gate enable is active at any instant.
- R5: While the selected external input keeps toggling, no failure is flagged.
- R6: If the selected external input stops, the flag is set and the code reads 0 between 12 and 24 slow cycles after the stop, and `clk_out` then runs at the fast RC clock. The flag is never set earlier than 12 slow cycles after the stop.
- R7: `irq` is high exactly when the failure flag is set and `irq_en` is high. A failure with `irq_en` low leaves `irq` low.
- R8: The failure flag stays set until a cycle with `wr_clr_fail` high clears it.
- R9: While the flag is set, writes of codes 2 or 3 are ignored (the code and `clk_out` are unchanged), and writes of codes 0 or 1 still take effect. After the flag is cleared, external codes are accepted again.
- R10: A stopped external input that is not selected raises no failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast RC clock, also clocks the control logic |
| clk_slow | input | 1 | Slow RC clock, clocks the activity supervisor |
| clk_ext0 | input | 1 | External clock input 0 |
| clk_ext1 | input | 1 | External clock input 1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load `wr_mode` into the source code |
| wr_mode | input | 2 | Requested source code |
| wr_clr_fail | input | 1 | Clear the failure flag |
| irq_en | input | 1 | Failure interrupt enable |
| clk_out | output | 1 | Selected, glitch-free system clock |
| mode_rd | output | 2 | Current source code |
| fail_flag | output | 1 | Sticky external-clock failure flag |
| irq | output | 1 | Failure interrupt request |

## Verification
The source code and the flag are registers in the fast domain. They are sampled at the falling edge after the rising edge that loads them, and `irq` is sampled 1 ns after `irq_en` changes. A clock handover needs two rising edges of the old source, two of the new source and a half period. The bench therefore waits 1.5 us, more than five slow periods, before it times two consecutive rising edges of `clk_out` against the chosen period. A failure is due about 17 to 20 slow cycles after the last external edge, plus three fast cycles. The bench checks that the flag is still low 12 slow cycles after the stop and that it is set 24 slow cycles after the stop. A monitor also records the shortest phase of `clk_out` over the whole run.

// File: rtl/clk_fo_pkg.sv
`timescale 1ns/1ps
package clk_fo_pkg;
    localparam int NSRC = 4;
    localparam int NEXT = 2;

    typedef enum logic [1:0] {
        SEL_FAST = 2'd0,
        SEL_SLOW = 2'd1,
        SEL_EXT0 = 2'd2,
        SEL_EXT1 = 2'd3
    } sel_e;

    typedef struct packed {
        sel_e            mode;
        logic [NSRC-1:0] onehot;
        logic            flag;
        logic [1:0]      fsync;
    } ctrl_st_t;
endpackage

// File: rtl/clk_fo_leg.sv
`timescale 1ns/1ps
module clk_fo_leg (
    input  logic clk,
    input  logic arst_n,
    input  logic want,
    output logic en,
    output logic gclk
);
    typedef struct packed {
        logic s1;
        logic s2;
    } leg_st_t;

    leg_st_t leg_d, leg_q;

    always_comb begin
        leg_d.s1 = want;
        leg_d.s2 = leg_q.s1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) leg_q <= '0;
        else         leg_q <= leg_d;
    end

    // enable changes only while this source is low
    always_ff @(negedge clk or negedge arst_n) begin
        if (!arst_n) en <= 1'b0;
        else         en <= leg_q.s2;
    end

    assign gclk = clk & en;
endmodule

// File: rtl/clk_fo_monitor.sv
`timescale 1ns/1ps
module clk_fo_monitor #(
    parameter int LIMIT = 16,
    parameter int NX    = 2
) (
    input  logic          clk_slow,
    input  logic          rst_n,
    input  logic [NX-1:0] clk_ext,
    input  logic [NX-1:0] watch,
    output logic          fail
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    typedef struct packed {
        logic [NX-1:0]    w1;
        logic [NX-1:0]    w2;
        logic [NX-1:0]    wp;
        logic [NX-1:0]    t1;
        logic [NX-1:0]    t2;
        logic [NX-1:0]    t3;
        logic [CNT_W-1:0] cnt;
        logic             fail;
    } mon_st_t;

    logic [NX-1:0] tog;
    mon_st_t mon_d, mon_q;
    logic watching, edge_seen;

    for (genvar i = 0; i < NX; i++) begin : g_tog
        logic t_q;
        always_ff @(posedge clk_ext[i] or negedge rst_n) begin
            if (!rst_n) t_q <= 1'b0;
            else        t_q <= ~t_q;
        end
        assign tog[i] = t_q;
    end

    always_comb begin
        mon_d     = mon_q;
        mon_d.w1  = watch;
        mon_d.w2  = mon_q.w1;
        mon_d.wp  = mon_q.w2;
        mon_d.t1  = tog;
        mon_d.t2  = mon_q.t1;
        mon_d.t3  = mon_q.t2;
        watching  = |mon_q.w2;
        edge_seen = |((mon_q.t2 ^ mon_q.t3) & mon_q.w2);
        if (!watching || (mon_q.w2 != mon_q.wp) || edge_seen)
            mon_d.cnt = '0;
        else if (mon_q.cnt != LIM)
            mon_d.cnt = mon_q.cnt + 1'b1;
        mon_d.fail = (mon_d.cnt == LIM);
    end

    always_ff @(posedge clk_slow or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign fail = mon_q.fail;

    // R10: no external source watched -> quiet counter and no failure
    assert_idle_when_unwatched_R10: assert property (@(posedge clk_slow) disable iff (!rst_n)
        !watching |=> (mon_q.cnt == '0) && !mon_q.fail);
endmodule

// File: rtl/clk_fo_ctrl.sv
`timescale 1ns/1ps
module clk_fo_ctrl
    import clk_fo_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_mode,
    input  logic            wr_clr_fail,
    input  logic            fail_async,
    output sel_e            mode,
    output logic [NSRC-1:0] onehot,
    output logic            flag
);
    localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

    ctrl_st_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fsync = {ctl_q.fsync[0], fail_async};
        if (wr_en && !(ctl_q.flag && wr_mode[1]))
            ctl_d.mode = sel_e'(wr_mode);
        if (wr_clr_fail)
            ctl_d.flag = 1'b0;
        if (ctl_q.fsync[1] && ctl_q.mode[1]) begin
            ctl_d.mode = SEL_FAST;
            ctl_d.flag = 1'b1;
        end
        ctl_d.onehot = ONE << ctl_d.mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: SEL_FAST, onehot: ONE, flag: 1'b0, fsync: 2'b00};
        else        ctl_q <= ctl_d;
    end

    assign mode   = ctl_q.mode;
    assign onehot = ctl_q.onehot;
    assign flag   = ctl_q.flag;

    assert_no_ext_while_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.flag |-> !ctl_q.mode[1]);

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.flag && !wr_clr_fail) |=> ctl_q.flag);

    assert_failover_to_fast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.flag) |-> (ctl_q.mode == SEL_FAST));
endmodule

// File: rtl/clk_failover_sel.sv
`timescale 1ns/1ps
module clk_failover_sel
    import clk_fo_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic       clk_fast,
    input  logic       clk_slow,
    input  logic       clk_ext0,
    input  logic       clk_ext1,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_mode,
    input  logic       wr_clr_fail,
    input  logic       irq_en,
    output logic       clk_out,
    output logic [1:0] mode_rd,
    output logic       fail_flag,
    output logic       irq
);
    localparam logic [NSRC-1:0] ONE = {{(NSRC-1){1'b0}}, 1'b1};

    logic [NSRC-1:0] clk_vec, sel_onehot, want, en, gclk, leg_rst_n;
    sel_e mode;
    logic flag, fail_slow;

    assign clk_vec = {clk_ext1, clk_ext0, clk_slow, clk_fast};

    clk_fo_ctrl u_ctrl (
        .clk        (clk_fast),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_mode    (wr_mode),
        .wr_clr_fail(wr_clr_fail),
        .fail_async (fail_slow),
        .mode       (mode),
        .onehot     (sel_onehot),
        .flag       (flag)
    );

    clk_fo_monitor #(.LIMIT(LIMIT), .NX(NEXT)) u_mon (
        .clk_slow(clk_slow),
        .rst_n   (rst_n),
        .clk_ext (clk_vec[NSRC-1 -: NEXT]),
        .watch   (sel_onehot[NSRC-1 -: NEXT]),
        .fail    (fail_slow)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_leg
        localparam logic [NSRC-1:0] SELF = ONE << i;
        assign want[i] = sel_onehot[i] & ~|(en & ~SELF);
        if (i >= NSRC - NEXT) begin : g_ext
            // a failed input may have stopped: release its gate at once
            assign leg_rst_n[i] = rst_n & ~flag;
        end else begin : g_int
            assign leg_rst_n[i] = rst_n;
        end
        clk_fo_leg u_leg (
            .clk   (clk_vec[i]),
            .arst_n(leg_rst_n[i]),
            .want  (want[i]),
            .en    (en[i]),
            .gclk  (gclk[i])
        );
    end

    assign clk_out   = |gclk;
    assign mode_rd   = mode;
    assign fail_flag = flag;
    assign irq       = flag & irq_en;

    always_comb begin
        if (rst_n) begin
            assert_one_leg_R4: assert ($countones(en) <= 1);
        end
    end
endmodule

// File: tb/clk_failover_sel_tb.sv
`timescale 1ns/1ps
module clk_failover_sel_tb;
    logic clk_fast = 1'b0, clk_slow = 1'b0, clk_ext0 = 1'b0, clk_ext1 = 1'b0;
    logic run0 = 1'b1, run1 = 1'b1;
    logic rst_n = 1'b0, wr_en = 1'b0, wr_clr_fail = 1'b0, irq_en = 1'b0;
    logic [1:0] wr_mode = 2'd0;
    logic clk_out, fail_flag, irq;
    logic [1:0] mode_rd;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0, mon_on = 1'b0;
    real last_edge = 0.0, min_phase = 1.0e9;

    always #5 clk_fast = ~clk_fast;
    always #35 clk_slow = ~clk_slow;
    always begin #13; clk_ext0 = run0 ? ~clk_ext0 : 1'b0; end
    always begin #15; clk_ext1 = run1 ? ~clk_ext1 : 1'b0; end

    clk_failover_sel u_dut (
        .clk_fast(clk_fast), .clk_slow(clk_slow), .clk_ext0(clk_ext0), .clk_ext1(clk_ext1),
        .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode), .wr_clr_fail(wr_clr_fail),
        .irq_en(irq_en), .clk_out(clk_out), .mode_rd(mode_rd), .fail_flag(fail_flag), .irq(irq)
    );

    always @(clk_out) begin
        if (mon_on && ($realtime - last_edge) < min_phase) min_phase = $realtime - last_edge;
        last_edge = $realtime;
    end

    function automatic real period_of(input int m);
        case (m)
            0: return 10.0;
            1: return 70.0;
            2: return 26.0;
            default: return 30.0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_period(input int m, input string req);
        real t1, p;
        @(posedge clk_out); t1 = $realtime;
        @(posedge clk_out); p = $realtime - t1;
        #1;
        chk((p > period_of(m) - 0.5) && (p < period_of(m) + 0.5), req, "clk_out period ps",
            int'(p * 1000.0), int'(period_of(m) * 1000.0));
    endtask

    task automatic write_mode(input int m);
        @(negedge clk_fast); wr_en = 1'b1; wr_mode = 2'(m);
        @(negedge clk_fast); wr_en = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk_fast); wr_clr_fail = 1'b1;
        @(negedge clk_fast); wr_clr_fail = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        #23 rst_n = 1'b1;
        #2000;
        mon_on = 1'b1;
        // R1 reset state
        chk(mode_rd == 2'd0, "R1", "mode", mode_rd, 0);
        chk(fail_flag == 1'b0, "R1", "flag", fail_flag, 0);
        chk(irq == 1'b0, "R1", "irq", irq, 0);
        chk_period(0, "R1");

        // R2 / R3 / R5: every ordered pair of distinct sources
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                if (a != b) begin
                    write_mode(a); #1500;
                    write_mode(b);
                    chk(mode_rd == 2'(b), "R2", "mode readback", mode_rd, b);
                    #1500;
                    chk_period(b, "R2");
                    chk(fail_flag == 1'b0, "R5", "flag while running", fail_flag, 0);
                end
            end
        end

        // R6 / R7: external input 0 stops with the interrupt disabled
        write_mode(2); #1500;
        chk_period(2, "R6");
        @(negedge clk_fast); run0 = 1'b0;
        #840;
        chk(fail_flag == 1'b0, "R6", "flag before 12 slow cycles", fail_flag, 0);
        #840;
        chk(fail_flag == 1'b1, "R6", "flag by 24 slow cycles", fail_flag, 1);
        chk(mode_rd == 2'd0, "R6", "mode after failover", mode_rd, 0);
        chk(irq == 1'b0, "R7", "irq while disabled", irq, 0);
        #1500;
        chk_period(0, "R6");
        run0 = 1'b1;

        // R9: external codes blocked while the flag is set, internal ones accepted
        write_mode(2);
        chk(mode_rd == 2'd0, "R9", "ext write ignored", mode_rd, 0);
        #1500;
        chk_period(0, "R9");
        write_mode(1);
        chk(mode_rd == 2'd1, "R9", "internal write accepted", mode_rd, 1);
        #1500;
        chk_period(1, "R9");
        write_mode(0); #1500;

        // R7 / R8: enable the interrupt, flag stays until cleared
        @(negedge clk_fast); irq_en = 1'b1; #1;
        chk(irq == 1'b1, "R7", "irq on enable", irq, 1);
        #2000;
        chk(fail_flag == 1'b1, "R8", "flag sticky", fail_flag, 1);
        clear_flag();
        chk(fail_flag == 1'b0, "R8", "flag cleared", fail_flag, 0);
        chk(irq == 1'b0, "R7", "irq after clear", irq, 0);

        // R6 / R7: external input 1 stops with the interrupt enabled
        write_mode(3); #1500;
        chk_period(3, "R2");
        @(negedge clk_fast); run1 = 1'b0;
        #1680;
        chk(fail_flag == 1'b1, "R6", "flag ext1", fail_flag, 1);
        chk(irq == 1'b1, "R7", "irq enabled", irq, 1);
        chk(mode_rd == 2'd0, "R6", "mode after ext1 failover", mode_rd, 0);
        #1500;
        chk_period(0, "R6");
        clear_flag();
        run1 = 1'b1; #200;
        write_mode(3);
        chk(mode_rd == 2'd3, "R9", "ext accepted after clear", mode_rd, 3);
        #1500;
        chk_period(3, "R9");
        chk(fail_flag == 1'b0, "R5", "ext1 running", fail_flag, 0);
        write_mode(0); #1500;

        // R10: unselected external input stops
        write_mode(1);
        @(negedge clk_fast); run0 = 1'b0;
        #3000;
        chk(fail_flag == 1'b0, "R10", "flag with unselected stop", fail_flag, 0);
        chk(mode_rd == 2'd1, "R10", "mode unchanged", mode_rd, 1);
        run0 = 1'b1;
        #500;

        // R3: shortest phase over the whole run
        chk(min_phase >= 4.9, "R3", "min phase ps", int'(min_phase * 1000.0), 5000);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule